// File: doc/BRIEF.md
# Decimal64 Multiplier with Binary-Integer Coefficients

This block multiplies two 64-bit decimal floating-point numbers whose coefficients are held as plain binary integers. Each operand is worth (-1)^s · C · 10^e, where C has at most 16 decimal digits and the stored exponent carries a bias of 398. A word whose bits 62:61 are not both set holds the coefficient directly in its low 53 bits. A word whose bits 62:61 are both set holds only the low 51 coefficient bits, and the upper three bits are implied as binary 100.

A pulse on `start` captures both operands. The block takes their signs, exponents and coefficients apart and forms the exact binary product of the coefficients. It then counts the decimal digits of that product. When the product has more than 16 digits, the block cuts it back to 16 digits with round-to-nearest-even. The quotient by the power of ten comes from a multiply by a precomputed, upward-rounded binary reciprocal, and a back-multiply supplies the exact remainder. The rounded value is packed again, and the result appears with `done` two clock edges after `start`. It holds there until the next operation completes.

Top module: `dec64_mul`

## Requirements
- R1: An operand whose bits 62:61 are not 11 is read as sign = bit 63, biased exponent = bits 62:53, coefficient = bits 52:0.
- R2: An operand whose bits 62:61 are 11 is read as sign = bit 63, biased exponent = bits 60:51, coefficient = 2^53 + bits 50:0.
- R3: The result sign (bit 63) is the XOR of the two operand signs.
- R4: When the coefficient product has at most 16 decimal digits, the result coefficient equals the product exactly. The biased exponent is ea + eb − 398 and `inexact` is 0.
- R5: When the product has q > 16 digits, the low x = q − 16 digits are removed and the exponent rises by x. `inexact` is 1 exactly when the removed part is nonzero.
- R6: Rounding is to nearest. A removed part of exactly half a unit rounds the kept 16-digit value to even.
- R7: If rounding up yields 10^16, the coefficient becomes 10^15 and the exponent rises by one more.
- R8: A result coefficient below 2^53 is packed with bits 62:53 = exponent and bits 52:0 = coefficient. Otherwise the result is packed with bits 62:61 = 11, bits 60:51 = exponent and bits 50:0 = the low coefficient bits.
- R9: `overflow` is 1 when the final biased exponent exceeds 767, and `underflow` is 1 when it is negative. The two never rise together, and the result word is not meaningful while either flag is set.
- R10: `done` is high for exactly one cycle, two rising edges after a cycle with `start` high. The outputs do not change in any other cycle.
- R11: While `rst_n` is low, `done`, `result`, `inexact`, `overflow` and `underflow` are 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Captures op_a and op_b this cycle |
| op_a | input | 64 | First decimal64 operand |
| op_b | input | 64 | Second decimal64 operand |
| result | output | 64 | Packed rounded product |
| inexact | output | 1 | Nonzero digits were discarded |
| overflow | output | 1 | Final biased exponent above 767 |
| underflow | output | 1 | Final biased exponent below 0 |
| done | output | 1 | One-cycle pulse, result valid |

## Verification
The assertions assume canonical operands whose coefficients stay below 10^16. Their range property on the packed coefficient depends on that bound, and so does the rule that an inexact result carries at least 15 digits. The assertions also assume `start` is a single-cycle pulse with at least two idle cycles before the next one. The stimulus keeps to these assumptions. It builds every operand from a coefficient list that ends at 9999999999999999, encodes each one in the form its size demands, and waits for `done` before the next start. Biased exponents 0 and 767 are among the swept values, so both flags are driven without leaving the valid encoding.

// File: rtl/dec64_pkg.sv
// Shared constants, the unpacked operand type and elaboration-time
// constant builders for the decimal64 multiplier.
// Assumes coefficients are canonical (below 10^16).
package dec64_pkg;
    localparam int WORD_W    = 64;
    localparam int EXP_W     = 10;
    localparam int COEF_W    = 54;
    localparam int DIGITS    = 16;
    localparam int EXP_BIAS  = 398;
    localparam int EXP_MAX   = 767;
    localparam int PROD_W    = 2 * COEF_W;
    localparam int XEXP_W    = EXP_W + 3;
    localparam int DROP_W    = $clog2(DIGITS + 1);
    localparam int CNT_W     = $clog2(2 * DIGITS + 1) + 1;
    localparam int RCP_SHIFT = 168;
    localparam int RCP_W     = RCP_SHIFT + 1;
    localparam int MUL_W     = PROD_W + RCP_W;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  bexp;
        logic [COEF_W-1:0] coef;
    } dec_fields_t;

    // Ten raised to n, held in the product width.
    function automatic logic [PROD_W-1:0] pow10(input int n);
        logic [PROD_W-1:0] v;
        v = PROD_W'(1);
        for (int i = 0; i < n; i++) v = v * PROD_W'(10);
        return v;
    endfunction

    // Reciprocal of 10^n scaled by 2^RCP_SHIFT and rounded upward.
    function automatic logic [RCP_W-1:0] recip10(input int n);
        logic [RCP_W-1:0] num;
        num = RCP_W'(1) << RCP_SHIFT;
        return num / RCP_W'(pow10(n)) + RCP_W'(1);
    endfunction
endpackage

// File: rtl/dec64_unpack.sv
// Splits one decimal64 word into sign, biased exponent and binary
// coefficient, handling both packing forms. Purely combinational.
// Assumes the long form only carries canonical coefficients.
module dec64_unpack import dec64_pkg::*; (
    input  logic [WORD_W-1:0] word,
    output dec_fields_t       fields
);
    // Select the field layout from the two bits below the sign.
    always_comb begin
        fields.sign = word[WORD_W-1];
        if (word[62:61] == 2'b11) begin
            fields.bexp = word[60:51];
            fields.coef = {3'b100, word[50:0]};
        end else begin
            fields.bexp = word[62:53];
            fields.coef = {1'b0, word[52:0]};
        end
    end
endmodule

// File: rtl/dec64_digits.sv
// Counts the decimal digits of the coefficient product against a
// generated table of powers of ten and reports how many low digits
// exceed the 16-digit precision. Purely combinational.
module dec64_digits import dec64_pkg::*; (
    input  logic [PROD_W-1:0] prod,
    output logic [DROP_W-1:0] drop
);
    localparam int MAXD = 2 * DIGITS;

    logic [MAXD:1] at_least;

    // One magnitude comparator per power of ten.
    for (genvar i = 1; i <= MAXD; i++) begin : g_cmp
        localparam logic [PROD_W-1:0] THRESH = pow10(i);
        assign at_least[i] = (prod >= THRESH);
    end

    logic [CNT_W-1:0] ndig;

    // Digit count is one plus the number of thresholds reached.
    always_comb begin
        ndig = CNT_W'(1) + CNT_W'($countones(at_least));
        drop = (ndig > CNT_W'(DIGITS)) ? DROP_W'(ndig - CNT_W'(DIGITS)) : '0;
    end
endmodule

// File: rtl/dec64_round.sv
// Removes 'drop' decimal digits from the product by multiplying with an
// upward-rounded reciprocal of 10^drop, recovers the exact remainder by
// back-multiplication and rounds to nearest-even. Reports the extra
// exponent increment (drop plus a carry to 10^16). Combinational.
// Assumes prod < 10^32 and drop <= 16.
module dec64_round import dec64_pkg::*; (
    input  logic [PROD_W-1:0] prod,
    input  logic [DROP_W-1:0] drop,
    output logic [COEF_W-1:0] coef,
    output logic              inexact,
    output logic [DROP_W-1:0] exp_adj
);
    localparam logic [PROD_W-1:0] COEF_LIMIT = pow10(DIGITS);
    localparam logic [PROD_W-1:0] COEF_FLOOR = pow10(DIGITS - 1);

    logic [RCP_W-1:0]  recip [0:DIGITS];
    logic [PROD_W-1:0] scale [0:DIGITS];

    // Constant tables of reciprocals and divisors for each digit count.
    for (genvar j = 0; j <= DIGITS; j++) begin : g_const
        localparam logic [RCP_W-1:0]  RCP = recip10(j);
        localparam logic [PROD_W-1:0] DIV = pow10(j);
        assign recip[j] = RCP;
        assign scale[j] = DIV;
    end

    logic [PROD_W-1:0] quo, rem, half, rounded;
    logic              up, carry;

    // Quotient by reciprocal, remainder by back-multiply, then round.
    always_comb begin
        quo     = PROD_W'((MUL_W'(prod) * MUL_W'(recip[drop])) >> RCP_SHIFT);
        rem     = prod - quo * scale[drop];
        half    = scale[drop] >> 1;
        up      = (drop != '0) && ((rem > half) || ((rem == half) && quo[0]));
        rounded = quo + PROD_W'(up);
        carry   = (rounded == COEF_LIMIT);
        coef    = carry ? COEF_W'(COEF_FLOOR) : COEF_W'(rounded);
        inexact = (rem != '0);
        exp_adj = drop + DROP_W'(carry);
    end
endmodule

// File: rtl/dec64_mul.sv
// Decimal64 multiplier, binary-integer coefficient encoding, rounding to
// nearest-even at 16 digits. Stage 1 unpacks and multiplies; stage 2
// counts digits, rounds, checks the exponent range and repacks.
// Assumes canonical finite operands and start pulses spaced >= 3 cycles.
module dec64_mul import dec64_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] result,
    output logic              inexact,
    output logic              overflow,
    output logic              underflow,
    output logic              done
);
    dec_fields_t fa, fb;

    dec64_unpack u_unpack_a (.word(op_a), .fields(fa));
    dec64_unpack u_unpack_b (.word(op_b), .fields(fb));

    logic                     s1_valid, s1_sign;
    logic [PROD_W-1:0]        s1_prod;
    logic signed [XEXP_W-1:0] s1_exp;

    // Stage 1: capture sign, exact coefficient product and exponent sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sign  <= 1'b0;
            s1_prod  <= '0;
            s1_exp   <= '0;
        end else begin
            s1_valid <= start;
            if (start) begin
                s1_sign <= fa.sign ^ fb.sign;
                s1_prod <= PROD_W'(fa.coef) * PROD_W'(fb.coef);
                s1_exp  <= XEXP_W'(fa.bexp) + XEXP_W'(fb.bexp) - XEXP_W'(EXP_BIAS);
            end
        end
    end

    logic [DROP_W-1:0] drop, exp_adj;
    logic [COEF_W-1:0] rcoef;
    logic              rinexact;

    dec64_digits u_digits (.prod(s1_prod), .drop(drop));

    dec64_round u_round (
        .prod    (s1_prod),
        .drop    (drop),
        .coef    (rcoef),
        .inexact (rinexact),
        .exp_adj (exp_adj)
    );

    localparam logic signed [XEXP_W-1:0] EXP_HI = XEXP_W'(EXP_MAX);

    logic signed [XEXP_W-1:0] fin_exp;
    logic [WORD_W-1:0]        packed_w;
    logic                     ovf, unf;

    // Final exponent, range flags and choice of packing form.
    always_comb begin
        fin_exp = s1_exp + XEXP_W'(exp_adj);
        ovf     = (fin_exp > EXP_HI);
        unf     = fin_exp[XEXP_W-1];
        if (!rcoef[COEF_W-1])
            packed_w = {s1_sign, fin_exp[EXP_W-1:0], rcoef[52:0]};
        else
            packed_w = {s1_sign, 2'b11, fin_exp[EXP_W-1:0], rcoef[50:0]};
    end

    // Stage 2: register the packed result and flags with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            inexact   <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= s1_valid;
            if (s1_valid) begin
                result    <= packed_w;
                inexact   <= rinexact;
                overflow  <= ovf;
                underflow <= unf;
            end
        end
    end
endmodule

// File: rtl/dec64_mul_chk.sv
// Property checker for dec64_mul, attached with bind. Observes ports only.
// Assumes canonical operands and isolated start pulses.
module dec64_mul_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        sign_a,
    input logic        sign_b,
    input logic [63:0] result,
    input logic        inexact,
    input logic        overflow,
    input logic        underflow,
    input logic        done
);
    logic [53:0] res_coef;

    // Coefficient carried by the packed result, either form.
    always_comb begin
        if (result[62:61] == 2'b11) res_coef = {3'b100, result[50:0]};
        else                        res_coef = {1'b0, result[52:0]};
    end

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##2 done);

    p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 2));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result) && $stable(inexact));

    p_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result[63] == ($past(sign_a, 2) ^ $past(sign_b, 2)));

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow));

    p_coef_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !overflow && !underflow) |-> res_coef < 54'd10000000000000000);

    p_inexact_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && inexact && !overflow && !underflow) |-> res_coef >= 54'd1000000000000000);

    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> !done && result == 64'd0);
endmodule

bind dec64_mul dec64_mul_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sign_a    (op_a[63]),
    .sign_b    (op_b[63]),
    .result    (result),
    .inexact   (inexact),
    .overflow  (overflow),
    .underflow (underflow),
    .done      (done)
);

// File: tb/tb_dec64_mul.sv
`timescale 1ns/1ps
module tb_dec64_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [63:0] result;
    logic        inexact, overflow, underflow, done;

    int nvec = 0;
    int nbad = 0;

    dec64_mul dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .result(result), .inexact(inexact), .overflow(overflow),
        .underflow(underflow), .done(done)
    );

    always #5 clk = ~clk;

    // Encode per R8 layout: short form below 2^53, long form otherwise.
    function automatic logic [63:0] enc(input logic s, input int e, input logic [63:0] c);
        logic [9:0] ef;
        ef = e[9:0];
        if (c < (64'd1 << 53)) return {s, ef, c[52:0]};
        return {s, 2'b11, ef, c[50:0]};
    endfunction

    // Arithmetic reference for R1..R9 using integer division.
    task automatic model(input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] r, output logic ix,
                         output logic ov, output logic un);
        logic [127:0] ca, cb, p, t, d, h, l;
        int ea, eb, e, q, x;
        if (a[62:61] == 2'b11) begin ea = int'(a[60:51]); ca = {74'd0, 3'b100, a[50:0]}; end
        else begin ea = int'(a[62:53]); ca = {75'd0, a[52:0]}; end
        if (b[62:61] == 2'b11) begin eb = int'(b[60:51]); cb = {74'd0, 3'b100, b[50:0]}; end
        else begin eb = int'(b[62:53]); cb = {75'd0, b[52:0]}; end
        p = ca * cb;
        q = 1;
        t = 128'd10;
        while (p >= t) begin q++; t = t * 128'd10; end
        e = ea + eb - 398;
        ix = 1'b0;
        h = p;
        if (q > 16) begin
            x = q - 16;
            d = 128'd1;
            for (int i = 0; i < x; i++) d = d * 128'd10;
            h = p / d;
            l = p % d;
            ix = (l != 0);
            if ((2 * l > d) || ((2 * l == d) && h[0])) h = h + 1;
            if (h == 128'd10000000000000000) begin h = 128'd1000000000000000; e = e + 1; end
            e = e + x;
        end
        ov = (e > 767);
        un = (e < 0);
        r = enc(a[63] ^ b[63], e, h[63:0]);
    endtask

    task automatic fail_line(input string tag, input string what,
                             input logic [63:0] act, input logic [63:0] exp);
        nbad++;
        $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    endtask

    // Apply one operation, then check done, flags and result at negedge.
    task automatic apply(input logic [63:0] a, input logic [63:0] b, input string tag);
        logic [63:0] er;
        logic eix, eov, eun;
        model(a, b, er, eix, eov, eun);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        nvec++;
        if (done !== 1'b1) fail_line(tag, "done", 64'(done), 64'd1);
        else if (overflow !== eov) fail_line(tag, "overflow", 64'(overflow), 64'(eov));
        else if (underflow !== eun) fail_line(tag, "underflow", 64'(underflow), 64'(eun));
        else if (!eov && !eun && result !== er) fail_line(tag, "result", result, er);
        else if (!eov && !eun && inexact !== eix) fail_line(tag, "inexact", 64'(inexact), 64'(eix));
    endtask

    logic [63:0] coefs [14];
    int          exps  [5][2];

    initial begin
        logic [63:0] held;
        coefs[0] = 64'd0;                 coefs[1] = 64'd1;
        coefs[2] = 64'd7;                 coefs[3] = 64'd10;
        coefs[4] = 64'd12;                coefs[5] = 64'd999;
        coefs[6] = 64'd123456789;         coefs[7] = 64'd9007199254740991;
        coefs[8] = 64'd9007199254740992;  coefs[9] = 64'd5000000000000000;
        coefs[10] = 64'd8333333333333333; coefs[11] = 64'd9999999999999999;
        coefs[12] = 64'd2000000000000003; coefs[13] = 64'd4294967296;
        exps[0] = '{398, 398}; exps[1] = '{200, 300}; exps[2] = '{0, 0};
        exps[3] = '{767, 767}; exps[4] = '{600, 560};

        // R11: reset state of all outputs.
        repeat (3) @(negedge clk);
        nvec++;
        if (done !== 1'b0 || result !== 64'd0 || inexact !== 1'b0 ||
            overflow !== 1'b0 || underflow !== 1'b0)
            fail_line("R11", "reset outputs", result, 64'd0);
        rst_n = 1'b1;

        // R6: tie with even kept value stays; tie with odd kept value rounds up.
        apply(enc(1'b0, 398, 64'd5), enc(1'b0, 398, 64'd2000000000000001), "R6");
        apply(enc(1'b0, 398, 64'd5), enc(1'b1, 398, 64'd2000000000000003), "R6");
        // R7: 12 * 8333333333333333 rounds up to 10^16 and renormalises.
        apply(enc(1'b0, 398, 64'd12), enc(1'b0, 398, 64'd8333333333333333), "R7");
        // R9: exponent far above 767 and below 0.
        apply(enc(1'b0, 767, 64'd3), enc(1'b0, 767, 64'd3), "R9");
        apply(enc(1'b0, 0, 64'd3), enc(1'b0, 0, 64'd3), "R9");
        // R4: small exact product.
        apply(enc(1'b1, 400, 64'd999), enc(1'b0, 390, 64'd7), "R4");

        // R10: inputs changed without start must not disturb held outputs.
        held = result;
        @(negedge clk);
        op_a = enc(1'b1, 10, 64'd77); op_b = enc(1'b1, 20, 64'd9999999999999999);
        repeat (3) @(negedge clk);
        nvec++;
        if (done !== 1'b0 || result !== held) fail_line("R10", "held result", result, held);

        // Sweep covering R1 R2 R3 R4 R5 R8 R9 over coefficient and exponent grid.
        for (int k = 0; k < 5; k++)
            for (int i = 0; i < 14; i++)
                for (int j = 0; j < 14; j++)
                    apply(enc(1'((i ^ j) & 1), exps[k][0], coefs[i]),
                          enc(1'(j & 1), exps[k][1], coefs[j]),
                          "R1/R2/R3/R4/R5/R8/R9");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        nbad++;
        $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule